// File: doc/BRIEF.md
# AXI Write-Requester Tag Pass-Through

This block sits on an AXI link between an upstream manager and a downstream subordinate and forwards all five channels with no added cycle. Each channel's valid and payload cross from the side that originates the channel to the other side. Each channel's ready travels back the opposite way in the same cycle. No register, buffer or FIFO is placed anywhere on the path.

The block changes one field on its way through. On the write address channel, the two low bits of the transaction ID are ORed into the user sideband at bits 6:5. A downstream shared cache can then tell which requesting core issued a write, even though it never sees the ID encoding itself. A parameter applies the same tagging to the read address channel. A second parameter turns tagging off, so the block becomes a plain wire-through.

Back-pressure rules follow from the zero-latency structure. A transfer completes in the cycle in which the originator's valid and the far side's ready are both high. The block neither stalls nor accepts anything on its own behalf. Valid is forwarded whatever the state of ready. The originator must therefore keep its payload stable while valid is high and ready is low, exactly as if no block were present.

Top module: `axi_user_tag_bridge`

## Requirements
- R1: In the same cycle, m_awvalid, m_awid, m_awaddr, m_awlen, m_awsize, m_awburst and m_awprot equal their s_aw* counterparts, whatever the state of any ready.
- R2: In the same cycle, m_wvalid, m_wdata, m_wstrb and m_wlast equal their s_w* counterparts.
- R3: In the same cycle, m_arvalid, m_arid, m_araddr, m_arlen, m_arsize, m_arburst and m_arprot equal their s_ar* counterparts.
- R4: With TAG_EN=1, m_awuser bit 5 equals s_awuser bit 5 OR s_awid bit 0, and m_awuser bit 6 equals s_awuser bit 6 OR s_awid bit 1. A tag bit that is already set in s_awuser stays set. ID bits above bit 1 have no effect.
- R5: Every m_awuser bit other than bits 6:5 equals the same bit of s_awuser.
- R6: With AR_TAG_EN=1, m_aruser is formed from s_aruser and s_arid by the rule of R4 and R5. With AR_TAG_EN=0, m_aruser equals s_aruser.
- R7: In the same cycle, s_awready, s_wready and s_arready equal m_awready, m_wready and m_arready, and m_bready and m_rready equal s_bready and s_rready.
- R8: In the same cycle, s_bvalid, s_bid, s_bresp, s_rvalid, s_rid, s_rdata, s_rresp and s_rlast equal their m_* counterparts.
- R9: With TAG_EN=0, m_awuser equals s_awuser and m_aruser equals s_aruser for any ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, used only for checking |
| rst_n | input | 1 | Active-low reset, used only for checking |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awid | input | ID_W | Upstream write ID |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awlen | input | 8 | Upstream write burst length |
| s_awsize | input | 3 | Upstream write beat size |
| s_awburst | input | 2 | Upstream write burst type |
| s_awprot | input | 3 | Upstream write protection |
| s_awuser | input | USER_W | Upstream write user sideband |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream write strobes |
| s_wlast | input | 1 | Upstream last write beat |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bid | output | ID_W | Upstream write response ID |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_arid | input | ID_W | Upstream read ID |
| s_araddr | input | ADDR_W | Upstream read address |
| s_arlen | input | 8 | Upstream read burst length |
| s_arsize | input | 3 | Upstream read beat size |
| s_arburst | input | 2 | Upstream read burst type |
| s_arprot | input | 3 | Upstream read protection |
| s_aruser | input | USER_W | Upstream read user sideband |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rid | output | ID_W | Upstream read ID |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| s_rlast | output | 1 | Upstream last read beat |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_awid | output | ID_W | Downstream write ID |
| m_awaddr | output | ADDR_W | Downstream write address |
| m_awlen | output | 8 | Downstream write burst length |
| m_awsize | output | 3 | Downstream write beat size |
| m_awburst | output | 2 | Downstream write burst type |
| m_awprot | output | 3 | Downstream write protection |
| m_awuser | output | USER_W | Downstream write user sideband, tagged |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | DATA_W | Downstream write data |
| m_wstrb | output | DATA_W/8 | Downstream write strobes |
| m_wlast | output | 1 | Downstream last write beat |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_bid | input | ID_W | Downstream write response ID |
| m_bresp | input | 2 | Downstream write response code |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_arid | output | ID_W | Downstream read ID |
| m_araddr | output | ADDR_W | Downstream read address |
| m_arlen | output | 8 | Downstream read burst length |
| m_arsize | output | 3 | Downstream read beat size |
| m_arburst | output | 2 | Downstream read burst type |
| m_arprot | output | 3 | Downstream read protection |
| m_aruser | output | USER_W | Downstream read user sideband |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rid | input | ID_W | Downstream read ID |
| m_rdata | input | DATA_W | Downstream read data |
| m_rresp | input | 2 | Downstream read response code |
| m_rlast | input | 1 | Downstream last read beat |

## Verification
The bench targets the tag merge first.

- An incoming user value that already has bits 6:5 set must keep them. A design that replaced the field instead of ORing into it would clear those bits.
- An ID whose high bits are set but whose low bits are zero must leave the user field untouched. A design that took the wrong ID slice, or shifted by the wrong amount, would set stray user bits.
- Valid asserted while ready is low, and ready asserted with no valid, must both forward unchanged. A design that gated one signal with the other would drop or invent transfers.

A second instance with tagging disabled catches any tag logic that leaks into plain mode.

// File: rtl/axi_tag_pkg.sv
package axi_tag_pkg;
  // Position of the requester tag inside the user sideband and its width.
  localparam int unsigned TAG_LSB_DFLT  = 5;
  localparam int unsigned TAG_BITS_DFLT = 2;
  // Fixed AXI control field widths.
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned PROT_W  = 3;
  localparam int unsigned RESP_W  = 2;
  localparam int unsigned ACTL_W  = LEN_W + SIZE_W + BURST_W + PROT_W;
endpackage

// File: rtl/axi_chan_relay.sv
// Zero-latency channel relay: valid and payload go forward, ready goes back.
module axi_chan_relay #(
  parameter int unsigned W = 8
) (
  input  logic         src_valid,
  output logic         src_ready,
  input  logic [W-1:0] src_data,
  output logic         dst_valid,
  input  logic         dst_ready,
  output logic [W-1:0] dst_data
);
  assign dst_valid = src_valid;
  assign dst_data  = src_data;
  assign src_ready = dst_ready;
endmodule

// File: rtl/axi_user_tag.sv
// Merges the low ID bits into a fixed field of the user sideband.
module axi_user_tag #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned USER_W   = 8,
  parameter int unsigned TAG_BITS = 2,
  parameter int unsigned TAG_LSB  = 5,
  parameter bit          ENABLE   = 1'b1
) (
  input  logic [ID_W-1:0]   id_in,
  input  logic [USER_W-1:0] user_in,
  output logic [USER_W-1:0] user_out
);
  localparam int unsigned TAG_MSB = TAG_LSB + TAG_BITS - 1;

  generate
    if (ENABLE) begin : g_tag
      logic [USER_W-1:0] tag_mask;
      always_comb begin
        tag_mask = '0;
        for (int k = 0; k < int'(TAG_BITS); k++) begin
          tag_mask[TAG_LSB + k] = id_in[k];
        end
      end
      assign user_out = user_in | tag_mask;
    end else begin : g_plain
      assign user_out = user_in;
    end
  endgenerate
endmodule

// File: rtl/axi_user_tag_bridge.sv
module axi_user_tag_bridge
  import axi_tag_pkg::*;
#(
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned USER_W    = 8,
  parameter int unsigned TAG_BITS  = TAG_BITS_DFLT,
  parameter int unsigned TAG_LSB   = TAG_LSB_DFLT,
  parameter bit          TAG_EN    = 1'b1,
  parameter bit          AR_TAG_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [7:0]          s_awlen,
  input  logic [2:0]          s_awsize,
  input  logic [1:0]          s_awburst,
  input  logic [2:0]          s_awprot,
  input  logic [USER_W-1:0]   s_awuser,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [7:0]          s_arlen,
  input  logic [2:0]          s_arsize,
  input  logic [1:0]          s_arburst,
  input  logic [2:0]          s_arprot,
  input  logic [USER_W-1:0]   s_aruser,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic [2:0]          m_awprot,
  output logic [USER_W-1:0]   m_awuser,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ID_W-1:0]     m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic [2:0]          m_arprot,
  output logic [USER_W-1:0]   m_aruser,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned AX_W   = ID_W + ADDR_W + ACTL_W;
  localparam int unsigned W_W    = DATA_W + STRB_W + 1;
  localparam int unsigned B_W    = ID_W + RESP_W;
  localparam int unsigned R_W    = ID_W + DATA_W + RESP_W + 1;
  localparam int unsigned TAG_MSB = TAG_LSB + TAG_BITS - 1;

  // ---------------- write address ----------------
  logic [AX_W-1:0] aw_in, aw_out;
  assign aw_in = {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awprot};

  axi_chan_relay #(.W(AX_W)) u_aw (
    .src_valid(s_awvalid), .src_ready(s_awready), .src_data(aw_in),
    .dst_valid(m_awvalid), .dst_ready(m_awready), .dst_data(aw_out)
  );
  assign {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot} = aw_out;

  axi_user_tag #(
    .ID_W(ID_W), .USER_W(USER_W), .TAG_BITS(TAG_BITS),
    .TAG_LSB(TAG_LSB), .ENABLE(TAG_EN)
  ) u_aw_tag (
    .id_in(s_awid), .user_in(s_awuser), .user_out(m_awuser)
  );

  // ---------------- write data ----------------
  logic [W_W-1:0] w_out;
  axi_chan_relay #(.W(W_W)) u_w (
    .src_valid(s_wvalid), .src_ready(s_wready), .src_data({s_wdata, s_wstrb, s_wlast}),
    .dst_valid(m_wvalid), .dst_ready(m_wready), .dst_data(w_out)
  );
  assign {m_wdata, m_wstrb, m_wlast} = w_out;

  // ---------------- write response (downstream originates) ----------------
  logic [B_W-1:0] b_out;
  axi_chan_relay #(.W(B_W)) u_b (
    .src_valid(m_bvalid), .src_ready(m_bready), .src_data({m_bid, m_bresp}),
    .dst_valid(s_bvalid), .dst_ready(s_bready), .dst_data(b_out)
  );
  assign {s_bid, s_bresp} = b_out;

  // ---------------- read address ----------------
  logic [AX_W-1:0] ar_in, ar_out;
  assign ar_in = {s_arid, s_araddr, s_arlen, s_arsize, s_arburst, s_arprot};

  axi_chan_relay #(.W(AX_W)) u_ar (
    .src_valid(s_arvalid), .src_ready(s_arready), .src_data(ar_in),
    .dst_valid(m_arvalid), .dst_ready(m_arready), .dst_data(ar_out)
  );
  assign {m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arprot} = ar_out;

  axi_user_tag #(
    .ID_W(ID_W), .USER_W(USER_W), .TAG_BITS(TAG_BITS),
    .TAG_LSB(TAG_LSB), .ENABLE(TAG_EN && AR_TAG_EN)
  ) u_ar_tag (
    .id_in(s_arid), .user_in(s_aruser), .user_out(m_aruser)
  );

  // ---------------- read data (downstream originates) ----------------
  logic [R_W-1:0] r_out;
  axi_chan_relay #(.W(R_W)) u_r (
    .src_valid(m_rvalid), .src_ready(m_rready), .src_data({m_rid, m_rdata, m_rresp, m_rlast}),
    .dst_valid(s_rvalid), .dst_ready(s_rready), .dst_data(r_out)
  );
  assign {s_rid, s_rdata, s_rresp, s_rlast} = r_out;

  // ---------------- checks ----------------
  assert_aw_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid == s_awvalid && m_awaddr == s_awaddr && m_awid == s_awid && m_awlen == s_awlen);

  assert_w_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid == s_wvalid && m_wdata == s_wdata && m_wstrb == s_wstrb && m_wlast == s_wlast);

  assert_ar_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid == s_arvalid && m_araddr == s_araddr && m_arid == s_arid);

  assert_ready_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready == m_awready && s_wready == m_wready && s_arready == m_arready &&
    m_bready == s_bready && m_rready == s_rready);

  assert_resp_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid == m_bvalid && s_bid == m_bid && s_rvalid == m_rvalid &&
    s_rid == m_rid && s_rdata == m_rdata && s_rlast == m_rlast);

  generate
    if (TAG_EN) begin : g_chk_tag
      assert_aw_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_awuser[TAG_MSB:TAG_LSB] == (s_awuser[TAG_MSB:TAG_LSB] | s_awid[TAG_BITS-1:0]));
      if (TAG_LSB > 0) begin : g_low
        assert_aw_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
          m_awuser[TAG_LSB-1:0] == s_awuser[TAG_LSB-1:0]);
      end
      if (TAG_MSB + 1 < USER_W) begin : g_high
        assert_aw_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
          m_awuser[USER_W-1:TAG_MSB+1] == s_awuser[USER_W-1:TAG_MSB+1]);
      end
    end else begin : g_chk_plain
      assert_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_awuser == s_awuser && m_aruser == s_aruser);
    end
  endgenerate
endmodule

// File: tb/test_axi_user_tag_bridge.sv
`timescale 1ns/1ps
module test_axi_user_tag_bridge;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, USER_W = 8, SW = DATA_W/8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;

  logic s_awvalid, s_wvalid, s_wlast, s_bready, s_arvalid, s_rready;
  logic [ID_W-1:0] s_awid, s_arid, m_bid, m_rid;
  logic [ADDR_W-1:0] s_awaddr, s_araddr;
  logic [7:0] s_awlen, s_arlen;
  logic [2:0] s_awsize, s_arsize, s_awprot, s_arprot;
  logic [1:0] s_awburst, s_arburst, m_bresp, m_rresp;
  logic [USER_W-1:0] s_awuser, s_aruser;
  logic [DATA_W-1:0] s_wdata, m_rdata;
  logic [SW-1:0] s_wstrb;
  logic m_awready, m_wready, m_bvalid, m_arready, m_rvalid, m_rlast;

  // outputs of tagged instance
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, s_rlast;
  logic [ID_W-1:0] s_bid, s_rid, m_awid, m_arid;
  logic [1:0] s_bresp, s_rresp, m_awburst, m_arburst;
  logic [DATA_W-1:0] s_rdata, m_wdata;
  logic m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
  logic [ADDR_W-1:0] m_awaddr, m_araddr;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize, m_awprot, m_arprot;
  logic [USER_W-1:0] m_awuser, m_aruser;
  logic [SW-1:0] m_wstrb;

  // outputs of plain instance
  logic p_awready, p_wready, p_bvalid, p_arready, p_rvalid, p_rlast;
  logic [ID_W-1:0] p_bid, p_rid, p_awid, p_arid;
  logic [1:0] p_bresp, p_rresp, p_awburst, p_arburst;
  logic [DATA_W-1:0] p_rdata, p_wdata;
  logic p_awvalid, p_wvalid, p_wlast, p_bready, p_arvalid, p_rready;
  logic [ADDR_W-1:0] p_awaddr, p_araddr;
  logic [7:0] p_awlen, p_arlen;
  logic [2:0] p_awsize, p_arsize, p_awprot, p_arprot;
  logic [USER_W-1:0] p_awuser, p_aruser;
  logic [SW-1:0] p_wstrb;

  axi_user_tag_bridge i_axi_user_tag_bridge (
    .clk, .rst_n,
    .s_awvalid, .s_awready, .s_awid, .s_awaddr, .s_awlen, .s_awsize, .s_awburst, .s_awprot, .s_awuser,
    .s_wvalid, .s_wready, .s_wdata, .s_wstrb, .s_wlast,
    .s_bvalid, .s_bready, .s_bid, .s_bresp,
    .s_arvalid, .s_arready, .s_arid, .s_araddr, .s_arlen, .s_arsize, .s_arburst, .s_arprot, .s_aruser,
    .s_rvalid, .s_rready, .s_rid, .s_rdata, .s_rresp, .s_rlast,
    .m_awvalid, .m_awready, .m_awid, .m_awaddr, .m_awlen, .m_awsize, .m_awburst, .m_awprot, .m_awuser,
    .m_wvalid, .m_wready, .m_wdata, .m_wstrb, .m_wlast,
    .m_bvalid, .m_bready, .m_bid, .m_bresp,
    .m_arvalid, .m_arready, .m_arid, .m_araddr, .m_arlen, .m_arsize, .m_arburst, .m_arprot, .m_aruser,
    .m_rvalid, .m_rready, .m_rid, .m_rdata, .m_rresp, .m_rlast
  );

  axi_user_tag_bridge #(.TAG_EN(1'b0)) i_axi_user_tag_bridge_plain (
    .clk, .rst_n,
    .s_awvalid, .s_awready(p_awready), .s_awid, .s_awaddr, .s_awlen, .s_awsize, .s_awburst, .s_awprot, .s_awuser,
    .s_wvalid, .s_wready(p_wready), .s_wdata, .s_wstrb, .s_wlast,
    .s_bvalid(p_bvalid), .s_bready, .s_bid(p_bid), .s_bresp(p_bresp),
    .s_arvalid, .s_arready(p_arready), .s_arid, .s_araddr, .s_arlen, .s_arsize, .s_arburst, .s_arprot, .s_aruser,
    .s_rvalid(p_rvalid), .s_rready, .s_rid(p_rid), .s_rdata(p_rdata), .s_rresp(p_rresp), .s_rlast(p_rlast),
    .m_awvalid(p_awvalid), .m_awready, .m_awid(p_awid), .m_awaddr(p_awaddr), .m_awlen(p_awlen),
    .m_awsize(p_awsize), .m_awburst(p_awburst), .m_awprot(p_awprot), .m_awuser(p_awuser),
    .m_wvalid(p_wvalid), .m_wready, .m_wdata(p_wdata), .m_wstrb(p_wstrb), .m_wlast(p_wlast),
    .m_bvalid, .m_bready(p_bready), .m_bid, .m_bresp,
    .m_arvalid(p_arvalid), .m_arready, .m_arid(p_arid), .m_araddr(p_araddr), .m_arlen(p_arlen),
    .m_arsize(p_arsize), .m_arburst(p_arburst), .m_arprot(p_arprot), .m_aruser(p_aruser),
    .m_rvalid, .m_rready(p_rready), .m_rid, .m_rdata, .m_rresp, .m_rlast
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: the two low ID bits set user bits 5 and 6.
  function automatic logic [USER_W-1:0] ref_user(input logic [USER_W-1:0] u,
                                                 input logic [ID_W-1:0] id, input bit en);
    logic [USER_W-1:0] r = u;
    if (en) begin
      if (id[0]) r[5] = 1'b1;
      if (id[1]) r[6] = 1'b1;
    end
    return r;
  endfunction

  task automatic drive_random();
    {s_awvalid, s_wvalid, s_wlast, s_bready, s_arvalid, s_rready} = 6'($urandom);
    {m_awready, m_wready, m_bvalid, m_arready, m_rvalid, m_rlast} = 6'($urandom);
    s_awid = 4'($urandom); s_arid = 4'($urandom); m_bid = 4'($urandom); m_rid = 4'($urandom);
    s_awaddr = $urandom; s_araddr = $urandom; s_wdata = $urandom; m_rdata = $urandom;
    s_awlen = 8'($urandom); s_arlen = 8'($urandom);
    s_awsize = 3'($urandom); s_arsize = 3'($urandom); s_awprot = 3'($urandom); s_arprot = 3'($urandom);
    s_awburst = 2'($urandom); s_arburst = 2'($urandom); m_bresp = 2'($urandom); m_rresp = 2'($urandom);
    s_awuser = 8'($urandom); s_aruser = 8'($urandom); s_wstrb = 4'($urandom);
  endtask

  task automatic check_all();
    chk("R1 awvalid", 64'(m_awvalid), 64'(s_awvalid));
    chk("R1 awfields", {m_awid, m_awlen, m_awsize, m_awburst, m_awprot, m_awaddr},
                       {s_awid, s_awlen, s_awsize, s_awburst, s_awprot, s_awaddr});
    chk("R2 w", {m_wvalid, m_wlast, m_wstrb, m_wdata}, {s_wvalid, s_wlast, s_wstrb, s_wdata});
    chk("R3 ar", {m_arvalid, m_arid, m_arlen, m_arsize, m_arburst, m_arprot, m_araddr},
                 {s_arvalid, s_arid, s_arlen, s_arsize, s_arburst, s_arprot, s_araddr});
    chk("R4 R5 awuser", 64'(m_awuser), 64'(ref_user(s_awuser, s_awid, 1'b1)));
    chk("R6 aruser", 64'(m_aruser), 64'(ref_user(s_aruser, s_arid, 1'b1)));
    chk("R7 ready", {s_awready, s_wready, s_arready, m_bready, m_rready},
                    {m_awready, m_wready, m_arready, s_bready, s_rready});
    chk("R8 b", {s_bvalid, s_bid, s_bresp}, {m_bvalid, m_bid, m_bresp});
    chk("R8 r", {s_rvalid, s_rid, s_rresp, s_rlast, s_rdata}, {m_rvalid, m_rid, m_rresp, m_rlast, m_rdata});
    chk("R9 plain user", {p_awuser, p_aruser}, {s_awuser, s_aruser});
    chk("R9 plain aw", {p_awvalid, p_awid, p_awaddr}, {s_awvalid, s_awid, s_awaddr});
  endtask

  task automatic directed(input logic [ID_W-1:0] id, input logic [USER_W-1:0] u,
                          input logic [USER_W-1:0] exp_tag);
    @(posedge clk); #1;
    s_awid = id; s_awuser = u; s_arid = id; s_aruser = u;
    @(negedge clk);
    chk("R4 directed awuser", 64'(m_awuser), 64'(exp_tag));
    chk("R6 directed aruser", 64'(m_aruser), 64'(exp_tag));
    chk("R9 directed plain", 64'(p_awuser), 64'(u));
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive_random();
    {s_awvalid, s_wvalid, s_arvalid, m_bvalid, m_rvalid} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state: no valid appears on either side
    chk("R1 idle awvalid", 64'(m_awvalid), 64'd0);
    chk("R8 idle bvalid", 64'({s_bvalid, s_rvalid}), 64'd0);
    rst_n = 1'b1;

    // valid high while ready low, and the reverse (R1, R7)
    @(posedge clk); #1;
    s_awvalid = 1'b1; m_awready = 1'b0; s_wvalid = 1'b0; m_wready = 1'b1;
    @(negedge clk);
    chk("R1 valid without ready", 64'({m_awvalid, s_awready}), 64'b10);
    chk("R7 ready without valid", 64'({m_wvalid, s_wready}), 64'b01);

    // tag corner cases (R4, R5, R6, R9)
    directed(4'b1100, 8'h00, 8'h00);   // high ID bits only: no change
    directed(4'b0011, 8'h00, 8'h60);   // both tag bits
    directed(4'b0001, 8'h9F, 8'hBF);   // bit 5 only, others kept
    directed(4'b0000, 8'hFF, 8'hFF);   // existing tag bits stay set
    directed(4'b0010, 8'h20, 8'h60);   // OR, not replace
    directed(4'b1110, 8'h81, 8'hC1);

    for (int c = 0; c < 400; c++) begin
      @(posedge clk); #1;
      drive_random();
      @(negedge clk);
      check_all();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule